// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative translation cache for a processor's memory pipeline. Every slot holds a virtual page tag, a physical page, an address-space number and a global flag. It also holds two per-mode permission masks, one for reads and one for writes, and two fault-on-access flags. A lookup port compares every slot against a virtual page and the current address-space number within the same cycle. It returns whether a slot matched, which slot it was, and the payload of that slot. Checking the permissions is left to the logic that uses these outputs.

New mappings are written through an insert port into the slot named by a rotating victim pointer. Three invalidation commands are provided. The first clears every slot. The second clears only the slots whose global flag is clear. The third clears the slots that match one page under the lookup rule. A separate port shows the slot under the victim pointer, and a strobe moves the pointer forward without writing. The depth is a parameter. A typical instruction-side instance uses 48 slots and a data-side instance uses 64.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is invalid, every lookup misses, and the victim pointer is 0.
- R2: A lookup hits only on a slot that is valid, whose tag equals `lkVpn`, and that either has its global flag set or holds an address-space number equal to `lkAsn`.
- R3: On a hit, `hitIdx` and the `hit*` payload outputs show the matching slot. On a miss, `hitIdx` and every payload output are zero. The lookup outputs are combinational on the stored state.
- R4: An insert writes the slot at the victim pointer and sets it valid, replacing whatever that slot held. The pointer then moves up by one, and it wraps from DEPTH-1 to 0.
- R5: `rdAdvance` moves the victim pointer forward by one and changes no slot. The `ptr*` outputs always show the slot at the pointer, including its valid bit.
- R6: `flushAll` invalidates every slot and puts the pointer at 0, whatever else is asserted in that cycle.
- R7: `flushProc` invalidates every slot whose global flag is clear and leaves global slots unchanged.
- R8: `flushPage` invalidates every valid slot whose tag equals `flushVpn` and that is global or holds `flushAsn`. All other slots are kept.
- R9: When more than one slot matches a lookup, the lowest slot index is reported.
- R10: An insert in a cycle with any flush command is dropped. It writes nothing and does not move the pointer.
- R11: An insert together with `rdAdvance` in the same cycle moves the pointer by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkVpn | input | VPN_W | Lookup virtual page |
| lkAsn | input | ASN_W | Current address-space number |
| hitOut | output | 1 | Lookup matched a slot |
| hitIdx | output | IDX_W | Index of the matching slot |
| hitPpn | output | PPN_W | Physical page of the matching slot |
| hitAsn | output | ASN_W | Stored address-space number of the matching slot |
| hitGlobal | output | 1 | Global flag of the matching slot |
| hitRdMask | output | MODES | Read-enable mask, one bit per mode |
| hitWrMask | output | MODES | Write-enable mask, one bit per mode |
| hitFaultRd | output | 1 | Fault-on-read flag |
| hitFaultWr | output | 1 | Fault-on-write flag |
| insValid | input | 1 | Insert strobe |
| insVpn | input | VPN_W | Tag to insert |
| insPpn | input | PPN_W | Physical page to insert |
| insAsn | input | ASN_W | Address-space number to insert |
| insGlobal | input | 1 | Global flag to insert |
| insRdMask | input | MODES | Read mask to insert |
| insWrMask | input | MODES | Write mask to insert |
| insFaultRd | input | 1 | Fault-on-read flag to insert |
| insFaultWr | input | 1 | Fault-on-write flag to insert |
| rdAdvance | input | 1 | Move the victim pointer forward |
| ptrIdx | output | IDX_W | Victim pointer |
| ptrValid | output | 1 | Valid bit of the slot at the pointer |
| ptrVpn | output | VPN_W | Tag of the slot at the pointer |
| ptrPpn | output | PPN_W | Physical page of the slot at the pointer |
| ptrAsn | output | ASN_W | Address-space number of the slot at the pointer |
| ptrGlobal | output | 1 | Global flag of the slot at the pointer |
| flushAll | input | 1 | Invalidate every slot |
| flushProc | input | 1 | Invalidate all non-global slots |
| flushPage | input | 1 | Invalidate slots matching flushVpn/flushAsn |
| flushVpn | input | VPN_W | Page for flushPage |
| flushAsn | input | ASN_W | Address-space number for flushPage |

## Verification
A wrong valid bit or tag in any slot becomes visible on the lookup outputs the moment the matching page and address-space pair is presented. The lookup is combinational, so this happens in the cycle after the faulty update. For that reason every page and address-space combination of a four-slot configuration is swept after each command, against a model kept in the bench. A wrong victim pointer appears on `ptrIdx` straight away. A misplaced insert appears later, when it overwrites the wrong slot, so the `ptr*` contents are compared after every cycle as well. Collisions between commands in one cycle are driven deliberately, as well as at random.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Strobes from the control module to the slot array
  typedef struct packed {
    logic wipeAll;   // clear every valid bit
    logic wipeProc;  // clear non-global valid bits
    logic wipePage;  // clear valid bits that match the flush page
    logic fill;      // write the slot at the victim pointer
    logic bump;      // move the victim pointer
  } tlbCmd_t;

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int DEPTH = 48,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  input  logic             rdAdvance,
  input  logic             flushAll,
  input  logic             flushProc,
  input  logic             flushPage,
  output tlbCmd_t          cmd,
  output logic [IDX_W-1:0] ptr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic anyFlush;
  logic [IDX_W-1:0] ptrNext;

  // Flush commands outrank an insert; a full wipe outranks everything.
  always_comb begin
    anyFlush     = flushAll | flushProc | flushPage;
    cmd.wipeAll  = flushAll;
    cmd.wipeProc = flushProc & ~flushAll;
    cmd.wipePage = flushPage & ~flushAll;
    cmd.fill     = insValid & ~anyFlush;
    cmd.bump     = (cmd.fill | rdAdvance) & ~flushAll;
  end

  always_comb begin
    if (ptr == LAST) ptrNext = '0;
    else             ptrNext = ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            ptr <= '0;
    else if (cmd.wipeAll) ptr <= '0;
    else if (cmd.bump)    ptr <= ptrNext;
  end

endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int DEPTH  = 48,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASN_W  = 8,
  parameter int PERM_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbCmd_t           cmd,
  input  logic [IDX_W-1:0]  ptr,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASN_W-1:0]  lkAsn,
  input  logic [VPN_W-1:0]  insVpn,
  input  logic [PPN_W-1:0]  insPpn,
  input  logic [ASN_W-1:0]  insAsn,
  input  logic              insGlobal,
  input  logic [PERM_W-1:0] insPerm,
  input  logic [VPN_W-1:0]  flushVpn,
  input  logic [ASN_W-1:0]  flushAsn,
  output logic              hit,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [PPN_W-1:0]  hitPpn,
  output logic [ASN_W-1:0]  hitAsn,
  output logic              hitGlobal,
  output logic [PERM_W-1:0] hitPerm,
  output logic              ptrValid,
  output logic [VPN_W-1:0]  ptrVpn,
  output logic [PPN_W-1:0]  ptrPpn,
  output logic [ASN_W-1:0]  ptrAsn,
  output logic              ptrGlobal
);

  logic [DEPTH-1:0]  vldQ;
  logic [DEPTH-1:0]  globQ;
  logic [VPN_W-1:0]  tagQ  [DEPTH];
  logic [PPN_W-1:0]  ppnQ  [DEPTH];
  logic [ASN_W-1:0]  asnQ  [DEPTH];
  logic [PERM_W-1:0] permQ [DEPTH];

  logic [DEPTH-1:0] lkMatch;
  logic [DEPTH-1:0] pgMatch;

  // One comparator pair per slot
  for (genvar g = 0; g < DEPTH; g++) begin : gCam
    assign lkMatch[g] = vldQ[g] && (tagQ[g] == lkVpn) &&
                        (globQ[g] || (asnQ[g] == lkAsn));
    assign pgMatch[g] = vldQ[g] && (tagQ[g] == flushVpn) &&
                        (globQ[g] || (asnQ[g] == flushAsn));
  end

  // Lowest matching index wins
  always_comb begin
    hitIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (lkMatch[i]) hitIdx = IDX_W'(i);
    end
    hit = |lkMatch;
  end

  always_comb begin
    if (hit) begin
      hitPpn    = ppnQ[hitIdx];
      hitAsn    = asnQ[hitIdx];
      hitGlobal = globQ[hitIdx];
      hitPerm   = permQ[hitIdx];
    end else begin
      hitPpn    = '0;
      hitAsn    = '0;
      hitGlobal = 1'b0;
      hitPerm   = '0;
    end
  end

  assign ptrValid  = vldQ[ptr];
  assign ptrVpn    = tagQ[ptr];
  assign ptrPpn    = ppnQ[ptr];
  assign ptrAsn    = asnQ[ptr];
  assign ptrGlobal = globQ[ptr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldQ  <= '0;
      globQ <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tagQ[i]  <= '0;
        ppnQ[i]  <= '0;
        asnQ[i]  <= '0;
        permQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (cmd.wipeAll) begin
          vldQ[i] <= 1'b0;
        end else if ((cmd.wipeProc && !globQ[i]) ||
                     (cmd.wipePage && pgMatch[i])) begin
          vldQ[i] <= 1'b0;
        end else if (cmd.fill && (ptr == IDX_W'(i))) begin
          vldQ[i]  <= 1'b1;
          globQ[i] <= insGlobal;
          tagQ[i]  <= insVpn;
          ppnQ[i]  <= insPpn;
          asnQ[i]  <= insAsn;
          permQ[i] <= insPerm;
        end
      end
    end
  end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int DEPTH = 48,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int ASN_W = 8,
  parameter int MODES = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VPN_W-1:0] lkVpn,
  input  logic [ASN_W-1:0] lkAsn,
  output logic             hitOut,
  output logic [IDX_W-1:0] hitIdx,
  output logic [PPN_W-1:0] hitPpn,
  output logic [ASN_W-1:0] hitAsn,
  output logic             hitGlobal,
  output logic [MODES-1:0] hitRdMask,
  output logic [MODES-1:0] hitWrMask,
  output logic             hitFaultRd,
  output logic             hitFaultWr,
  input  logic             insValid,
  input  logic [VPN_W-1:0] insVpn,
  input  logic [PPN_W-1:0] insPpn,
  input  logic [ASN_W-1:0] insAsn,
  input  logic             insGlobal,
  input  logic [MODES-1:0] insRdMask,
  input  logic [MODES-1:0] insWrMask,
  input  logic             insFaultRd,
  input  logic             insFaultWr,
  input  logic             rdAdvance,
  output logic [IDX_W-1:0] ptrIdx,
  output logic             ptrValid,
  output logic [VPN_W-1:0] ptrVpn,
  output logic [PPN_W-1:0] ptrPpn,
  output logic [ASN_W-1:0] ptrAsn,
  output logic             ptrGlobal,
  input  logic             flushAll,
  input  logic             flushProc,
  input  logic             flushPage,
  input  logic [VPN_W-1:0] flushVpn,
  input  logic [ASN_W-1:0] flushAsn
);

  localparam int PERM_W = 2 * MODES + 2;

  tlbCmd_t           cmd;
  logic [PERM_W-1:0] insPerm;
  logic [PERM_W-1:0] hitPerm;

  assign insPerm = {insRdMask, insWrMask, insFaultRd, insFaultWr};
  assign {hitRdMask, hitWrMask, hitFaultRd, hitFaultWr} = hitPerm;

  tlb_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .insValid(insValid), .rdAdvance(rdAdvance),
    .flushAll(flushAll), .flushProc(flushProc), .flushPage(flushPage),
    .cmd(cmd), .ptr(ptrIdx)
  );

  tlb_array #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .VPN_W(VPN_W), .PPN_W(PPN_W),
    .ASN_W(ASN_W), .PERM_W(PERM_W)
  ) uArray (
    .clk(clk), .rstN(rstN), .cmd(cmd), .ptr(ptrIdx),
    .lkVpn(lkVpn), .lkAsn(lkAsn),
    .insVpn(insVpn), .insPpn(insPpn), .insAsn(insAsn),
    .insGlobal(insGlobal), .insPerm(insPerm),
    .flushVpn(flushVpn), .flushAsn(flushAsn),
    .hit(hitOut), .hitIdx(hitIdx), .hitPpn(hitPpn), .hitAsn(hitAsn),
    .hitGlobal(hitGlobal), .hitPerm(hitPerm),
    .ptrValid(ptrValid), .ptrVpn(ptrVpn), .ptrPpn(ptrPpn),
    .ptrAsn(ptrAsn), .ptrGlobal(ptrGlobal)
  );

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int DEPTH = 48,
  parameter int PPN_W = 20,
  parameter int ASN_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             insValid,
  input logic             rdAdvance,
  input logic             flushAll,
  input logic             flushProc,
  input logic             flushPage,
  input logic [IDX_W-1:0] ptrIdx,
  input logic             ptrValid,
  input logic             hitOut,
  input logic [IDX_W-1:0] hitIdx,
  input logic [PPN_W-1:0] hitPpn,
  input logic [ASN_W-1:0] hitAsn,
  input logic             hitGlobal,
  input logic [ASN_W-1:0] lkAsn
);

  function automatic logic [IDX_W-1:0] stepOf(logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // R4
  ins_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && !flushAll && !flushProc && !flushPage) |=>
      (ptrIdx == stepOf($past(ptrIdx))));

  // R5
  adv_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAdvance && !insValid && !flushAll) |=> (ptrIdx == stepOf($past(ptrIdx))));

  // R6
  wipe_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> (ptrIdx == '0 && !ptrValid && !hitOut));

  // R10
  flush_over_ins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((flushProc || flushPage) && insValid && !rdAdvance && !flushAll) |=>
      $stable(ptrIdx));

  // R2
  space_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitOut |-> (hitGlobal || hitAsn == lkAsn));

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hitOut |-> (hitIdx == '0 && hitPpn == '0 && !hitGlobal));

  // R4
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ptrIdx <= IDX_W'(DEPTH - 1));

endmodule

bind asid_tlb tlb_chk #(.DEPTH(DEPTH), .PPN_W(PPN_W), .ASN_W(ASN_W)) uChk (
  .clk(clk), .rstN(rstN), .insValid(insValid), .rdAdvance(rdAdvance),
  .flushAll(flushAll), .flushProc(flushProc), .flushPage(flushPage),
  .ptrIdx(ptrIdx), .ptrValid(ptrValid), .hitOut(hitOut), .hitIdx(hitIdx),
  .hitPpn(hitPpn), .hitAsn(hitAsn), .hitGlobal(hitGlobal), .lkAsn(lkAsn)
);

// File: tb/tb_asid_tlb.sv
`timescale 1ns/1ps
module tb_asid_tlb;

  localparam int D  = 4;
  localparam int VW = 4;
  localparam int PW = 6;
  localparam int AW = 2;
  localparam int MW = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [VW-1:0] lkVpn = '0;
  logic [AW-1:0] lkAsn = '0;
  logic hitOut, hitGlobal, hitFaultRd, hitFaultWr;
  logic [IW-1:0] hitIdx;
  logic [PW-1:0] hitPpn;
  logic [AW-1:0] hitAsn;
  logic [MW-1:0] hitRdMask, hitWrMask;
  logic insValid = 1'b0, insGlobal = 1'b0, insFaultRd = 1'b0, insFaultWr = 1'b0;
  logic [VW-1:0] insVpn = '0;
  logic [PW-1:0] insPpn = '0;
  logic [AW-1:0] insAsn = '0;
  logic [MW-1:0] insRdMask = '0, insWrMask = '0;
  logic rdAdvance = 1'b0;
  logic [IW-1:0] ptrIdx;
  logic ptrValid, ptrGlobal;
  logic [VW-1:0] ptrVpn;
  logic [PW-1:0] ptrPpn;
  logic [AW-1:0] ptrAsn;
  logic flushAll = 1'b0, flushProc = 1'b0, flushPage = 1'b0;
  logic [VW-1:0] flushVpn = '0;
  logic [AW-1:0] flushAsn = '0;

  asid_tlb #(.DEPTH(D), .VPN_W(VW), .PPN_W(PW), .ASN_W(AW), .MODES(MW)) dut (
    .clk(clk), .rstN(rstN), .lkVpn(lkVpn), .lkAsn(lkAsn),
    .hitOut(hitOut), .hitIdx(hitIdx), .hitPpn(hitPpn), .hitAsn(hitAsn),
    .hitGlobal(hitGlobal), .hitRdMask(hitRdMask), .hitWrMask(hitWrMask),
    .hitFaultRd(hitFaultRd), .hitFaultWr(hitFaultWr),
    .insValid(insValid), .insVpn(insVpn), .insPpn(insPpn), .insAsn(insAsn),
    .insGlobal(insGlobal), .insRdMask(insRdMask), .insWrMask(insWrMask),
    .insFaultRd(insFaultRd), .insFaultWr(insFaultWr), .rdAdvance(rdAdvance),
    .ptrIdx(ptrIdx), .ptrValid(ptrValid), .ptrVpn(ptrVpn), .ptrPpn(ptrPpn),
    .ptrAsn(ptrAsn), .ptrGlobal(ptrGlobal),
    .flushAll(flushAll), .flushProc(flushProc), .flushPage(flushPage),
    .flushVpn(flushVpn), .flushAsn(flushAsn)
  );

  int nChk = 0;
  int nFail = 0;

  // Bench model of the slots
  logic          mV [D];
  logic          mG [D];
  logic [VW-1:0] mT [D];
  logic [AW-1:0] mA [D];
  logic [PW-1:0] mP [D];
  int            mPtr;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Permissions derive from the physical page in this bench
  function automatic logic [9:0] permOf(logic [PW-1:0] p);
    return {p[3:0], ~p[3:0], p[4], p[5]};
  endfunction

  task automatic cyc(bit ins, logic [VW-1:0] v, logic [AW-1:0] a, bit g,
                     logic [PW-1:0] p, bit adv, bit fA, bit fPr, bit fPg,
                     logic [VW-1:0] fv, logic [AW-1:0] fa);
    bit wr;
    @(negedge clk);
    insValid = ins; insVpn = v; insAsn = a; insGlobal = g; insPpn = p;
    {insRdMask, insWrMask, insFaultRd, insFaultWr} = permOf(p);
    rdAdvance = adv; flushAll = fA; flushProc = fPr; flushPage = fPg;
    flushVpn = fv; flushAsn = fa;
    @(posedge clk);
    if (fA) begin
      for (int i = 0; i < D; i++) mV[i] = 1'b0;
      mPtr = 0;
    end else begin
      for (int i = 0; i < D; i++) begin
        if ((fPr && !mG[i]) ||
            (fPg && mV[i] && mT[i] == fv && (mG[i] || mA[i] == fa)))
          mV[i] = 1'b0;
      end
      wr = ins && !fPr && !fPg;
      if (wr) begin
        mV[mPtr] = 1'b1; mG[mPtr] = g; mT[mPtr] = v; mA[mPtr] = a; mP[mPtr] = p;
      end
      if (wr || adv) mPtr = (mPtr + 1) % D;
    end
    #1;
    insValid = 1'b0; rdAdvance = 1'b0;
    flushAll = 1'b0; flushProc = 1'b0; flushPage = 1'b0;
  endtask

  // Every page/space pair against the model
  task automatic sweep(string tag);
    logic [21:0] act, exp;
    bit eh;
    int ei;
    for (int v = 0; v < 16; v++) begin
      for (int a = 0; a < 4; a++) begin
        lkVpn = VW'(v); lkAsn = AW'(a);
        #1;
        eh = 1'b0; ei = 0;
        for (int i = D - 1; i >= 0; i--) begin
          if (mV[i] && mT[i] == VW'(v) && (mG[i] || mA[i] == AW'(a))) begin
            eh = 1'b1; ei = i;
          end
        end
        if (eh) exp = {1'b1, IW'(ei), mP[ei], mA[ei], mG[ei], permOf(mP[ei])};
        else    exp = '0;
        act = {hitOut, hitIdx, hitPpn, hitAsn, hitGlobal,
               hitRdMask, hitWrMask, hitFaultRd, hitFaultWr};
        chk(act == exp, tag, 32'(act), 32'(exp));
      end
    end
  endtask

  task automatic chkPtr(string tag);
    logic [15:0] act, exp;
    act = {ptrIdx, ptrValid, ptrVpn, ptrPpn, ptrAsn, ptrGlobal};
    exp = {IW'(mPtr), mV[mPtr], mT[mPtr], mP[mPtr], mA[mPtr], mG[mPtr]};
    chk(act == exp, tag, 32'(act), 32'(exp));
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < D; i++) begin
      mV[i] = 0; mG[i] = 0; mT[i] = '0; mA[i] = '0; mP[i] = '0;
    end
    mPtr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1: empty after reset
    chk(ptrIdx == 0 && !ptrValid, "R1 reset pointer", 32'({ptrIdx, ptrValid}), 0);
    sweep("R1 reset lookup");

    // R4: fill every slot, watching the pointer step
    cyc(1, 4'd3, 2'd1, 0, 6'h11, 0, 0, 0, 0, 0, 0); chkPtr("R4 step");
    cyc(1, 4'd5, 2'd2, 1, 6'h22, 0, 0, 0, 0, 0, 0); chkPtr("R4 step");
    cyc(1, 4'd3, 2'd2, 0, 6'h33, 0, 0, 0, 0, 0, 0); chkPtr("R4 step");
    cyc(1, 4'd9, 2'd0, 0, 6'h2c, 0, 0, 0, 0, 0, 0);
    chk(ptrIdx == 0, "R4 wrap", 32'(ptrIdx), 0);
    sweep("R2 R3 full table");

    // R9: overwrite slot 0 so that page 5 space 3 matches slots 0 and 1
    cyc(1, 4'd5, 2'd3, 0, 6'h3a, 0, 0, 0, 0, 0, 0);
    lkVpn = 4'd5; lkAsn = 2'd3; #1;
    chk(hitOut && hitIdx == 0, "R9 lowest index", 32'({hitOut, hitIdx}), 32'({1'b1, 2'd0}));
    sweep("R9 R4 overwrite");

    // R5: advance only
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0); chkPtr("R5 advance");
    sweep("R5 no slot change");

    // R11: insert with advance moves once
    cyc(1, 4'd7, 2'd1, 1, 6'h05, 1, 0, 0, 0, 0, 0); chkPtr("R11 single step");
    sweep("R11 lookup");

    // R10, R8: insert dropped under page flush of page 3 space 2
    cyc(1, 4'd12, 2'd0, 0, 6'h15, 0, 0, 0, 1, 4'd3, 2'd2);
    chkPtr("R10 insert dropped");
    sweep("R8 page flush");

    // R7: process flush keeps global slots
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0); chkPtr("R7 ptr");
    sweep("R7 process flush");

    // R6: refill then wipe together with advance and insert
    cyc(1, 4'd1, 2'd1, 0, 6'h01, 0, 0, 0, 0, 0, 0);
    cyc(1, 4'd2, 2'd2, 1, 6'h02, 0, 0, 0, 0, 0, 0);
    cyc(1, 4'd6, 2'd0, 0, 6'h06, 1, 1, 0, 0, 0, 0);
    chk(ptrIdx == 0 && !ptrValid, "R6 wipe pointer", 32'({ptrIdx, ptrValid}), 0);
    sweep("R6 wipe lookup");

    // Mixed traffic with colliding commands
    lf = 16'hace1;
    for (int n = 0; n < 300; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0] | lf[1], lf[5:2], lf[7:6], lf[8], {lf[11:9], lf[4:2]}, lf[12],
          (lf[15:13] == 3'b111) && lf[0], lf[15:13] == 3'b010,
          lf[15:14] == 2'b11, {lf[3:2], lf[9:8]}, lf[7:6]);
      chkPtr("R4 R5 R10 R11 mixed ptr");
      sweep("R2 R6 R7 R8 R9 mixed lookup");
    end

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule